// File: doc/BRIEF.md
# Time Base and Decrementer

This block keeps a free-running time base and a down-counting decrementer for a processor core. Both advance only on cycles where the tick-enable input is high. The tick is produced elsewhere from a reference clock. Software reads the time base as two half-width words and can overwrite either half on its own. The decrementer can be read and written as one word.

The decrementer raises a sticky pending flag in two cases. The first is when a tick arrives while it holds zero, and at that point it also reloads to all ones. The second is when a software write turns its sign bit from clear to set. An acknowledge input clears the flag. A separate reinitialise input, used at start-up or after a change of tick frequency, loads all ones and raises no interrupt.

A parameter selects a real-time-clock variant. In that variant the low half of the time base is masked on both reads and writes.

Top module: `tbase_dec`

## Requirements
- R1: After reset, both time-base halves read zero, the decrementer reads all ones and the pending flag is low.
- R2: A tick with no time-base write adds one to the full-width time base, so a carry out of the low half reaches the high half. With no tick and no write, the time base holds its value.
- R3: A low-half write replaces the low half and keeps the high half. A high-half write replaces the high half and keeps the low half. Both halves may be written in the same cycle. Any time-base write takes priority over a tick in the same cycle.
- R4: A tick decrements a non-zero decrementer by exactly one.
- R5: A tick while the decrementer holds zero reloads it with all ones and sets the pending flag.
- R6: A decrementer write loads the written value. It sets the pending flag if, and only if, the written value has its most significant bit set and the value held before the write had that bit clear. A write takes priority over a tick in the same cycle.
- R7: A reinitialise pulse loads all ones into the decrementer and never sets the pending flag. It takes priority over a write and over a tick in the same cycle.
- R8: The pending flag stays set until an acknowledge pulse clears it. If a set event and an acknowledge fall in the same cycle, the flag ends up set.
- R9: With the real-time-clock variant enabled, the low half is ANDed with a keep mask both when it is written and when it is read. The mask clears the RTC_MSB_DROP top bits and the RTC_LSB_DROP bottom bits; the defaults give 0x3FFFFF80. The high half is not masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base advance enable |
| tb_lo_we_i | input | 1 | Write the low half of the time base |
| tb_hi_we_i | input | 1 | Write the high half of the time base |
| dec_we_i | input | 1 | Write the decrementer |
| wdata_i | input | TB_W/2 | Write data; the decrementer takes the low DEC_W bits |
| reinit_i | input | 1 | Load all ones into the decrementer without an interrupt |
| ack_i | input | 1 | Clear the pending flag |
| tb_lo_o | output | TB_W/2 | Low half of the time base (masked in the clock variant) |
| tb_hi_o | output | TB_W/2 | High half of the time base |
| dec_o | output | DEC_W | Decrementer value |
| dec_irq_o | output | 1 | Decrementer interrupt pending |

## Verification
The bench builds two instances, each with a 16-bit time base and an 8-bit decrementer. The first is the plain variant. The second is the clock variant with two bits dropped at each end of the low half, which gives a keep mask of 0x3C. These narrow widths let 300 ticks carry from the low half into the high half. They also make it possible to sweep every low-half and high-half write value. The sign-flip rule is swept over every new decrementer value against a spread of prior values. Decrementer expiry is reached in a few ticks, and collisions of reinitialise, write, tick and acknowledge are checked against each other.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    DOP_HOLD,
    DOP_TICK,
    DOP_LOAD,
    DOP_REINIT
  } dec_op_e;

  // Keep mask over w bits, dropping lsb_drop low bits and msb_drop high bits
  function automatic logic [63:0] keep_mask(int w, int lsb_drop, int msb_drop);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w && i >= lsb_drop && i < w - msb_drop) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int TB_W = 64,
  parameter int HALF_W = TB_W / 2,
  parameter logic [HALF_W-1:0] LO_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);

  logic [TB_W-1:0] tb_q;
  logic            wr_any;

  assign wr_any = lo_we_i | hi_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q <= '0;
    end else if (wr_any) begin
      if (lo_we_i) tb_q[HALF_W-1:0]    <= wdata_i & LO_MASK;
      if (hi_we_i) tb_q[TB_W-1:HALF_W] <= wdata_i;
    end else if (tick_i) begin
      tb_q <= tb_q + TB_W'(1);
    end
  end

  assign lo_o = tb_q[HALF_W-1:0] & LO_MASK;
  assign hi_o = tb_q[TB_W-1:HALF_W];

  a_r2_tick_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_any |=> tb_q == $past(tb_q) + TB_W'(1));

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_any |=> $stable(tb_q));

  a_r3_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i && !hi_we_i |=> hi_o == $past(hi_o));

  a_r3_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i && !lo_we_i |=> lo_o == $past(lo_o));

  a_r3_hi_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> hi_o == $past(wdata_i));

endmodule

// File: rtl/dec_counter.sv
module dec_counter
  import tbase_pkg::*;
#(
  parameter int DEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             we_i,
  input  logic [DEC_W-1:0] wdata_i,
  input  logic             reinit_i,
  output logic [DEC_W-1:0] val_o,
  output logic             event_o
);

  localparam int MSB = DEC_W - 1;

  logic [DEC_W-1:0] dec_q, dec_d;
  dec_op_e          op;
  logic             at_zero;

  assign at_zero = (dec_q == '0);

  always_comb begin
    if (reinit_i)    op = DOP_REINIT;
    else if (we_i)   op = DOP_LOAD;
    else if (tick_i) op = DOP_TICK;
    else             op = DOP_HOLD;
  end

  always_comb begin
    dec_d   = dec_q;
    event_o = 1'b0;
    unique case (op)
      DOP_REINIT: dec_d = '1;
      DOP_LOAD: begin
        dec_d   = wdata_i;
        event_o = wdata_i[MSB] & ~dec_q[MSB];
      end
      DOP_TICK: begin
        if (at_zero) begin
          dec_d   = '1;
          event_o = 1'b1;
        end else begin
          dec_d = dec_q - DEC_W'(1);
        end
      end
      default: dec_d = dec_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dec_q <= '1;
    else         dec_q <= dec_d;
  end

  assign val_o = dec_q;

  a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !we_i && !reinit_i && dec_q != '0 |=> dec_q == $past(dec_q) - DEC_W'(1));

  a_r5_expiry_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !we_i && !reinit_i && dec_q == '0 |=> dec_q == '1);

  a_r6_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !reinit_i |=> dec_q == $past(wdata_i));

  a_r7_reinit_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> dec_q == '1);

  a_r7_reinit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |-> !event_o);

endmodule

// File: rtl/pend_flag.sv
module pend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic pend_o
);

  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (ack_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !set_i |=> !pend_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i && !set_i |=> $stable(pend_o));

endmodule

// File: rtl/tbase_dec.sv
module tbase_dec
  import tbase_pkg::*;
#(
  parameter int TB_W         = 64,
  parameter int DEC_W        = 32,
  parameter bit RTC_MODE     = 1'b0,
  parameter int RTC_LSB_DROP = 7,
  parameter int RTC_MSB_DROP = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 tb_lo_we_i,
  input  logic                 tb_hi_we_i,
  input  logic                 dec_we_i,
  input  logic [TB_W/2-1:0]    wdata_i,
  input  logic                 reinit_i,
  input  logic                 ack_i,
  output logic [TB_W/2-1:0]    tb_lo_o,
  output logic [TB_W/2-1:0]    tb_hi_o,
  output logic [DEC_W-1:0]     dec_o,
  output logic                 dec_irq_o
);

  localparam int HALF_W = TB_W / 2;
  localparam logic [63:0] FULL_MASK = keep_mask(HALF_W, RTC_LSB_DROP, RTC_MSB_DROP);
  localparam logic [HALF_W-1:0] LO_MASK = RTC_MODE ? FULL_MASK[HALF_W-1:0] : {HALF_W{1'b1}};

  logic dec_event;

  tbase_counter #(
    .TB_W   (TB_W),
    .HALF_W (HALF_W),
    .LO_MASK(LO_MASK)
  ) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .lo_we_i(tb_lo_we_i),
    .hi_we_i(tb_hi_we_i),
    .wdata_i(wdata_i),
    .lo_o   (tb_lo_o),
    .hi_o   (tb_hi_o)
  );

  dec_counter #(
    .DEC_W(DEC_W)
  ) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .we_i    (dec_we_i),
    .wdata_i (wdata_i[DEC_W-1:0]),
    .reinit_i(reinit_i),
    .val_o   (dec_o),
    .event_o (dec_event)
  );

  pend_flag u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (dec_event),
    .ack_i (ack_i),
    .pend_o(dec_irq_o)
  );

  a_r6_sign_flip_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_we_i && !reinit_i && wdata_i[DEC_W-1] && !dec_o[DEC_W-1] |=> dec_irq_o);

  a_r9_lo_masked_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_lo_we_i |=> (tb_lo_o & ~LO_MASK) == '0);

endmodule

// File: tb/sim_tbase_dec.sv
`timescale 1ns/1ps
module sim_tbase_dec;

  localparam int TB_W  = 16;
  localparam int HW    = 8;
  localparam int DEC_W = 8;
  localparam logic [7:0] MASK1 = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, lo_we = 0, hi_we = 0, dec_we = 0, reinit = 0, ack = 0;
  logic [HW-1:0] wdata = '0;
  logic [HW-1:0] lo0, hi0, lo1, hi1;
  logic [DEC_W-1:0] dec0, dec1;
  logic irq0, irq1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_tb, m_tb1;
  logic [7:0]  m_dec;
  logic        m_irq;

  always #2 clk = ~clk;

  tbase_dec #(.TB_W(TB_W), .DEC_W(DEC_W), .RTC_MODE(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tb_lo_we_i(lo_we), .tb_hi_we_i(hi_we),
    .dec_we_i(dec_we), .wdata_i(wdata), .reinit_i(reinit), .ack_i(ack),
    .tb_lo_o(lo0), .tb_hi_o(hi0), .dec_o(dec0), .dec_irq_o(irq0));

  tbase_dec #(.TB_W(TB_W), .DEC_W(DEC_W), .RTC_MODE(1'b1),
              .RTC_LSB_DROP(2), .RTC_MSB_DROP(2)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tb_lo_we_i(lo_we), .tb_hi_we_i(hi_we),
    .dec_we_i(dec_we), .wdata_i(wdata), .reinit_i(reinit), .ack_i(ack),
    .tb_lo_o(lo1), .tb_hi_o(hi1), .dec_o(dec1), .dec_irq_o(irq1));

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "tb_lo", 16'(lo0), 16'(m_tb[7:0]));
    chk(req, "tb_hi", 16'(hi0), 16'(m_tb[15:8]));
    chk(req, "dec", 16'(dec0), 16'(m_dec));
    chk(req, "irq", 16'(irq0), 16'(m_irq));
    chk("R9", "rtc_lo", 16'(lo1), 16'(m_tb1[7:0] & MASK1));
    chk("R9", "rtc_hi", 16'(hi1), 16'(m_tb1[15:8]));
  endtask

  task automatic cyc(bit tk, bit lw, bit hw, bit dw, logic [7:0] d, bit ri, bit ak, string req);
    bit ev;
    tick = tk; lo_we = lw; hi_we = hw; dec_we = dw; wdata = d; reinit = ri; ack = ak;
    ev = 1'b0;
    if (ri) m_dec = 8'hFF;
    else if (dw) begin
      ev = d[7] && !m_dec[7];
      m_dec = d;
    end else if (tk) begin
      if (m_dec == 8'h00) begin m_dec = 8'hFF; ev = 1'b1; end
      else m_dec = m_dec - 8'd1;
    end
    if (ev) m_irq = 1'b1;
    else if (ak) m_irq = 1'b0;
    if (lw || hw) begin
      if (lw) begin m_tb[7:0] = d; m_tb1[7:0] = d & MASK1; end
      if (hw) begin m_tb[15:8] = d; m_tb1[15:8] = d; end
    end else if (tk) begin
      m_tb = m_tb + 16'd1;
      m_tb1 = m_tb1 + 16'd1;
    end
    @(posedge clk); #1;
    tick = 0; lo_we = 0; hi_we = 0; dec_we = 0; reinit = 0; ack = 0;
    check_all(req);
  endtask

  initial begin
    m_tb = '0; m_tb1 = '0; m_dec = 8'hFF; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1");

    // R2: carry from low half into high half, then idle hold
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0, 8'h00, 0, 1, "R2");
    for (int i = 0; i < 5; i++)   cyc(0, 0, 0, 0, 8'h00, 0, 0, "R2");

    // R3: every half value, with and without a colliding tick
    for (int v = 0; v < 256; v++) begin
      cyc(v[0], 1, 0, 0, 8'(v), 0, 1, "R3");
      cyc(v[1], 0, 1, 0, 8'(255 - v), 0, 1, "R3");
      cyc(1, 0, 0, 0, 8'h00, 0, 1, "R3");
    end
    cyc(1, 1, 1, 0, 8'hA5, 0, 1, "R3");

    // R4/R5: countdown through zero
    cyc(0, 0, 0, 1, 8'h03, 0, 1, "R4");
    cyc(0, 0, 0, 0, 8'h00, 0, 1, "R8");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 8'h00, 0, 0, "R4");
    cyc(1, 0, 0, 0, 8'h00, 0, 0, "R5");
    cyc(1, 0, 0, 0, 8'h00, 0, 0, "R5");

    // R8: sticky, ack clears, set beats ack
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 8'h00, 0, 0, "R8");
    cyc(0, 0, 0, 0, 8'h00, 0, 1, "R8");
    cyc(0, 0, 0, 1, 8'h00, 0, 1, "R8");
    cyc(1, 0, 0, 0, 8'h00, 0, 1, "R8");

    // R6: sign-flip rule, all new values against spread of old values
    for (int o = 0; o < 256; o += 5) begin
      for (int n = 0; n < 256; n++) begin
        cyc(0, 0, 0, 1, 8'(o), 0, 0, "R6");
        cyc(0, 0, 0, 0, 8'h00, 0, 1, "R6");
        cyc(n[2], 0, 0, 1, 8'(n), 0, 0, "R6");
      end
    end

    // R7: reinit beats write and tick, never sets the flag
    cyc(0, 0, 0, 1, 8'h10, 0, 1, "R7");
    cyc(0, 0, 0, 0, 8'h00, 0, 1, "R7");
    cyc(1, 0, 0, 1, 8'h80, 1, 0, "R7");
    cyc(0, 0, 0, 1, 8'h00, 0, 0, "R7");
    cyc(1, 0, 0, 0, 8'h00, 1, 0, "R7");
    cyc(0, 0, 0, 0, 8'h00, 1, 0, "R7");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule